// File: doc/BRIEF.md
# Nibble-to-Byte Delimiter Aligner

This block sits behind a burst-mode clock/data recovery device. The device delivers one 4-bit nibble per cycle of its recovered clock. The block pairs consecutive nibbles into a running bit stream and searches that stream for a 16-bit burst delimiter. The delimiter may end at any bit position relative to the nibble pairing. Once found, every later byte is cut on the true boundary, so the first byte presented is the first payload byte after the delimiter.

While the block is unlocked it is silent apart from a one-cycle delimiter-found pulse. That pulse marks the start of payload for the receive state machine downstream. The alignment then holds for the rest of the burst. An end-of-burst input from the surrounding logic, or reset, drops the lock and restarts the search.

Top module: `nib_delim_align`

## Requirements
- R1: Within a nibble, `nib_in[3]` is the earliest-received bit. Two consecutive nibbles make one byte, so `byte_vld` is never high in two consecutive cycles.
- R2: The delimiter 16'hB598, first-received bit in bit 15, is found wherever it ends relative to the nibble pairing (all 8 bit offsets). `delim_hit` is a one-cycle pulse, raised in the cycle after the clock edge that captures the nibble completing the byte slot in which the delimiter ends.
- R3: Only an exact 16-bit match counts. A pattern differing from the delimiter in a single bit produces neither `delim_hit` nor any `byte_vld`.
- R4: After a hit, each `byte_vld` carries the next 8 consecutive bits of the stream, with the earliest bit in `byte_out[7]`. The first payload byte appears exactly 2 cycles after `delim_hit`.
- R5: No `byte_vld` is produced in a burst before its delimiter has been found.
- R6: While locked, further delimiter patterns are ignored. They raise no `delim_hit` and pass through as ordinary aligned data bytes.
- R7: A high `burst_end` clears the lock, the nibble pairing and the bit history. The nibble presented in that same cycle is discarded. No `byte_vld` follows until a new delimiter is received, and the search then resumes.
- R8: Synchronous active-high `rst` clears the lock. In the cycle after reset, `byte_vld`, `delim_hit` and `byte_out` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered clock, one nibble per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| nib_in | input | 4 | Received nibble, bit 3 earliest |
| burst_end | input | 1 | End of current burst; clears lock and pairing |
| byte_out | output | 8 | Aligned byte, bit 7 earliest |
| byte_vld | output | 1 | `byte_out` holds a new aligned byte |
| delim_hit | output | 1 | One-cycle pulse when the delimiter is found |

## Verification
The bench builds the block with its default widths: 4-bit nibbles, 8-bit bytes and the 16-bit delimiter 16'hB598. At these sizes, zero-bit prefixes of 0 to 7 bits (and some longer ones) after a burst start place the delimiter end at every one of the eight bit offsets of the byte slot. Each offset is checked for pulse timing and exact payload recovery. With the same defaults, a single flipped delimiter bit, a second delimiter inside a locked burst and a delimiter nibble lost in the end-of-burst cycle each give a short, fully predictable stream.

// File: rtl/na_pkg.sv
package na_pkg;
  parameter int NA_NIB_W   = 4;
  parameter int NA_DELIM_W = 16;
  parameter logic [NA_DELIM_W-1:0] NA_DELIM_DEF = 16'hB598;
endpackage

// File: rtl/na_pairer.sv
module na_pairer #(
  parameter int NIB_W = 4,
  parameter int SR_W  = 23
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic [NIB_W-1:0] nib,
  output logic [SR_W-1:0] win,
  output logic            byte_evt
);
  localparam int HIST_W = SR_W - NIB_W;

  logic [HIST_W-1:0] hist_q;
  logic              phase_q;

  // newest bits at the low end; the nibble's bit 3 is the oldest of the four
  assign win      = {hist_q, nib};
  assign byte_evt = phase_q & ~clr;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      hist_q  <= '0;
      phase_q <= 1'b0;
    end else begin
      hist_q  <= win[HIST_W-1:0];
      phase_q <= ~phase_q;
    end
  end
endmodule

// File: rtl/na_matcher.sv
module na_matcher #(
  parameter int BYTE_W  = 8,
  parameter int DELIM_W = 16,
  parameter int SR_W    = 23,
  parameter logic [DELIM_W-1:0] DELIM = 16'hB598,
  localparam int OFF_W  = $clog2(BYTE_W)
) (
  input  logic [SR_W-1:0]  win,
  output logic             hit,
  output logic [OFF_W-1:0] off
);
  logic [BYTE_W-1:0] cand;

  // one comparator per bit offset; offset k = delimiter ended k bits ago
  for (genvar g = 0; g < BYTE_W; g++) begin : g_cmp
    assign cand[g] = (win[g +: DELIM_W] == DELIM);
  end

  // the largest offset ended first in the bit stream, so it wins
  always_comb begin
    hit = 1'b0;
    off = '0;
    for (int k = 0; k < BYTE_W; k++) begin
      if (cand[k]) begin
        hit = 1'b1;
        off = OFF_W'(k);
      end
    end
  end
endmodule

// File: rtl/na_lock.sv
module na_lock #(
  parameter int BYTE_W = 8,
  parameter int SR_W   = 23,
  localparam int OFF_W = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              byte_evt,
  input  logic [SR_W-1:0]   win,
  input  logic              hit,
  input  logic [OFF_W-1:0]  off,
  output logic [BYTE_W-1:0] byte_out,
  output logic              byte_vld,
  output logic              delim_hit,
  output logic              locked_q
);
  logic [OFF_W-1:0] off_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      locked_q  <= 1'b0;
      off_q     <= '0;
      byte_out  <= '0;
      byte_vld  <= 1'b0;
      delim_hit <= 1'b0;
    end else begin
      byte_vld  <= 1'b0;
      delim_hit <= 1'b0;
      if (byte_evt) begin
        if (locked_q) begin
          byte_vld <= 1'b1;
          byte_out <= win[off_q +: BYTE_W];
        end else if (hit) begin
          locked_q  <= 1'b1;
          off_q     <= off;
          delim_hit <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/nib_delim_align.sv
module nib_delim_align
  import na_pkg::*;
#(
  parameter int NIB_W   = NA_NIB_W,
  parameter int DELIM_W = NA_DELIM_W,
  parameter logic [DELIM_W-1:0] DELIM = NA_DELIM_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NIB_W-1:0] nib_in,
  input  logic             burst_end,
  output logic [2*NIB_W-1:0] byte_out,
  output logic             byte_vld,
  output logic             delim_hit
);
  localparam int BYTE_W = 2 * NIB_W;
  localparam int SR_W   = DELIM_W + BYTE_W - 1;
  localparam int OFF_W  = $clog2(BYTE_W);

  logic [SR_W-1:0]  win;
  logic             byte_evt;
  logic             hit;
  logic [OFF_W-1:0] off;
  logic             lock_q;

  na_pairer #(.NIB_W(NIB_W), .SR_W(SR_W)) u_pair (
    .clk(clk), .rst(rst), .clr(burst_end), .nib(nib_in),
    .win(win), .byte_evt(byte_evt)
  );

  na_matcher #(.BYTE_W(BYTE_W), .DELIM_W(DELIM_W), .SR_W(SR_W), .DELIM(DELIM)) u_match (
    .win(win), .hit(hit), .off(off)
  );

  na_lock #(.BYTE_W(BYTE_W), .SR_W(SR_W)) u_lock (
    .clk(clk), .rst(rst), .clr(burst_end), .byte_evt(byte_evt),
    .win(win), .hit(hit), .off(off),
    .byte_out(byte_out), .byte_vld(byte_vld), .delim_hit(delim_hit),
    .locked_q(lock_q)
  );
endmodule

// File: rtl/na_align_chk.sv
module na_align_chk (
  input logic clk,
  input logic rst,
  input logic burst_end,
  input logic byte_vld,
  input logic delim_hit,
  input logic locked
);
  // R1
  vld_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    byte_vld |=> !byte_vld);

  // R5
  vld_needs_lock_chk: assert property (@(posedge clk) disable iff (rst)
    byte_vld |-> locked);

  // R2
  hit_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    delim_hit |=> !delim_hit);

  // R6
  no_rehit_chk: assert property (@(posedge clk) disable iff (rst)
    (locked && !burst_end) |=> !delim_hit);

  // R7
  end_clears_chk: assert property (@(posedge clk) disable iff (rst)
    burst_end |=> (!locked && !byte_vld && !delim_hit));

  // R8
  reset_quiet_chk: assert property (@(posedge clk)
    $fell(rst) |-> (!byte_vld && !delim_hit && !locked));
endmodule

bind nib_delim_align na_align_chk u_chk (
  .clk(clk), .rst(rst), .burst_end(burst_end),
  .byte_vld(byte_vld), .delim_hit(delim_hit), .locked(lock_q)
);

// File: tb/nib_delim_align_bench.sv
module nib_delim_align_bench;
  localparam logic [15:0] DLM = 16'hB598;
  localparam int NV = 10;
  // {prefix zero-bit count, 3 payload bytes}
  localparam logic [27:0] VEC [NV] = '{
    {4'd0,  24'h3CA50F}, {4'd1,  24'h12F0E7}, {4'd2,  24'hFFFFFF},
    {4'd3,  24'h000001}, {4'd4,  24'h8001C6}, {4'd5,  24'h5A5A5A},
    {4'd6,  24'hDEAD99}, {4'd7,  24'h7E817E}, {4'd9,  24'hB598B5},
    {4'd14, 24'h0102FE}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] nib_in = '0;
  logic burst_end = 1'b0;
  logic [7:0] byte_out;
  logic byte_vld, delim_hit;

  always #10 clk = ~clk;

  nib_delim_align u_nib_delim_align (
    .clk(clk), .rst(rst), .nib_in(nib_in), .burst_end(burst_end),
    .byte_out(byte_out), .byte_vld(byte_vld), .delim_hit(delim_hit)
  );

  int nchk = 0, nfail = 0;
  int hits, nb, early, gapbad, cyc, hit_cyc, first_cyc;
  logic prev_vld = 1'b0;
  logic [7:0] got [16];
  logic [3:0] acc;
  int nacc = 0;

  always @(negedge clk) begin
    cyc++;
    if (delim_hit) begin hits++; hit_cyc = cyc; end
    if (byte_vld) begin
      if (hits == 0) early++;
      else begin
        if (nb == 0) first_cyc = cyc;
        if (nb < 16) got[nb] = byte_out;
        nb++;
      end
      if (prev_vld) gapbad++;
    end
    prev_vld = byte_vld;
  end

  task automatic clr_mon();
    hits = 0; nb = 0; early = 0; gapbad = 0; hit_cyc = 0; first_cyc = 0;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive_nib(input logic [3:0] n);
    nib_in = n;
    @(negedge clk);
  endtask

  task automatic push_bit(input logic b);
    acc = {acc[2:0], b};
    nacc++;
    if (nacc == 4) begin drive_nib(acc); nacc = 0; end
  endtask

  task automatic push_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) push_bit(v[i]);
  endtask

  task automatic flush();
    while (nacc != 0) push_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_nib(4'h0);
  endtask

  task automatic pulse_end(input logic [3:0] n);
    burst_end = 1'b1;
    nib_in = n;
    @(negedge clk);
    burst_end = 1'b0;
    nacc = 0;
    #1 clr_mon();
  endtask

  initial begin
    #(20 * 150000);
    nfail++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    clr_mon();
    repeat (3) @(negedge clk);
    // R8: outputs quiet in reset
    chk(byte_vld == 0 && delim_hit == 0 && byte_out == 0, "R8 reset state",
        {byte_out, byte_vld, delim_hit}, 0);
    rst = 1'b0;
    drive_nib(4'h0);

    for (int v = 0; v < NV; v++) begin
      pulse_end(4'h0);
      push_bits(32'(VEC[v][27:24]) * 0, int'(VEC[v][27:24]));
      push_bits(32'(DLM), 16);
      push_bits(32'(VEC[v][23:0]), 24);
      flush();
      chk(hits == 1, $sformatf("R2 hit count prefix %0d", VEC[v][27:24]), hits, 1);
      chk(first_cyc - hit_cyc == 2, "R4 first byte latency", first_cyc - hit_cyc, 2);
      chk(got[0] == VEC[v][23:16], "R4 byte0", got[0], VEC[v][23:16]);
      chk(got[1] == VEC[v][15:8],  "R4 byte1", got[1], VEC[v][15:8]);
      chk(got[2] == VEC[v][7:0],   "R1 byte2 bit order", got[2], VEC[v][7:0]);
      chk(early == 0, "R5 no byte before hit", early, 0);
      chk(gapbad == 0, "R1 byte spacing", gapbad, 0);
    end

    // R3: single flipped delimiter bit
    pulse_end(4'h0);
    push_bits(0, 3);
    push_bits(32'(DLM ^ 16'h0010), 16);
    push_bits(32'h00C3A5, 24);
    flush();
    chk(hits == 0, "R3 no hit on near miss", hits, 0);
    chk(nb == 0 && early == 0, "R3 no bytes on near miss", nb + early, 0);

    // R6: second delimiter inside a locked burst is data
    pulse_end(4'h0);
    push_bits(0, 3);
    push_bits(32'(DLM), 16);
    push_bits(32'hC3, 8);
    push_bits(32'(DLM), 16);
    push_bits(32'h5A, 8);
    flush();
    chk(hits == 1, "R6 single hit", hits, 1);
    chk({got[0], got[1], got[2], got[3]} == 32'hC3B5985A, "R6 bytes",
        {got[0], got[1], got[2], got[3]}, 32'hC3B5985A);

    // R7: end of burst drops lock; no bytes afterwards
    pulse_end(4'h0);
    push_bits(0, 5);
    push_bits(32'(DLM), 16);
    push_bits(32'h77, 8);
    pulse_end(4'h0);
    for (int i = 0; i < 12; i++) drive_nib(4'h9);
    chk(nb == 0 && early == 0 && hits == 0, "R7 silent after end", nb + early + hits, 0);

    // R7: nibble in the end-of-burst cycle is discarded
    pulse_end(4'hB);
    push_bits(32'h598, 12);
    push_bits(32'h1234, 16);
    flush();
    chk(hits == 0, "R7 end-cycle nibble dropped", hits, 0);

    // R8: reset while locked
    pulse_end(4'h0);
    push_bits(32'(DLM), 16);
    push_bits(32'hAB, 8);
    flush();
    rst = 1'b1;
    drive_nib(4'h0);
    drive_nib(4'h0);
    chk(byte_vld == 0 && delim_hit == 0 && byte_out == 0, "R8 reset while locked",
        {byte_out, byte_vld, delim_hit}, 0);
    rst = 1'b0;
    drive_nib(4'h0);
    #1 clr_mon();
    for (int i = 0; i < 10; i++) drive_nib(4'h5);
    chk(nb == 0 && early == 0, "R8 lock cleared by reset", nb + early, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule